// File: doc/BRIEF.md
# FIFO Retransmit-From-Mark Controller

This block is a single-clock synchronous FIFO whose read side can bookmark the word currently held in its output register and later replay the stream from that word. While a bookmark is held, the write side keeps writing, but it stops one lap short of the bookmarked slot, so the replayable data is never overwritten. When the write side reaches that slot it pushes back through the full flag; it does not drop data silently. A build-time parameter selects one of two read styles. In standard mode every word is fetched by an explicit read strobe and an empty flag shows availability. In fall-through mode the head word appears on the output by itself and an active-low ready flag marks it as valid.

A replay request rewinds the read pointer to the bookmark and starts a fixed setup window. During that window the availability flag of the active mode is forced to "nothing to read". A bookmark request is taken only when enough words separate the write and read pointers. A request that fails this check is dropped and latches a sticky error bit. The storage is an internal array with a registered read port, so it can map onto block RAM.

Top module: `fifo_rtm_ctrl`

## Requirements
- R1: A write occurs on a clock edge with `wr_n` low and `full_n` high. In standard mode a clock edge with `rd_n` low and `empty_n` high places the next word in first-in first-out order on `dout`, visible after that edge.
- R2: With DEPTH words held and not yet read, `full_n` is low and writes are ignored. Reading a word frees a slot.
- R3: With `mark` high and `rt_active` low, an edge on which the mode's availability condition holds (standard: `empty_n` high; fall-through: `ready_n` low) and R9 is met sets `rt_active` and bookmarks the word now on `dout`. An edge with `mark` low clears `rt_active`. A later bookmark replaces the earlier one.
- R4: A replay starts on an edge with `rt_active` high, `rt_n` low, `rd_n` high and no setup in progress. With `rd_n` low, or with `rt_active` low, `rt_n` low has no effect.
- R5: For the SETUP_LEN (default 2) edges that follow a replay start, `empty_n` is low, `ready_n` is high and reads are blocked.
- R6: In standard mode, the first read after setup returns the bookmarked word and later reads continue in order.
- R7: In fall-through mode, `ready_n` low means `dout` holds a valid head word. That word is loaded without `rd_n`, and each edge with `rd_n` low consumes it. After setup the bookmarked word is loaded on the next edge without `rd_n`, and later words need `rd_n` low.
- R8: While `rt_active` is high, the write pointer cannot advance to DEPTH words past the bookmark. At that point `full_n` is low and writes are ignored. Clearing `rt_active` lifts the limit.
- R9: A bookmark is accepted only if the count of stored, not yet read words is between MIN_GAP (default 128) and DEPTH-2 inclusive. Otherwise it is ignored and `mark_err` goes high and stays high until `rst`.
- R10: After `rst`: `empty_n` low, `full_n` high, `ready_n` high, `rt_active` low, `mark_err` low.
- R11: In standard mode a bookmark request while `empty_n` is low is ignored and does not set `mark_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Write strobe, active low |
| din | input | DW | Write data |
| full_n | output | 1 | Low when no write can be accepted (capacity or bookmark guard) |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Replay request, active low |
| mark | input | 1 | Bookmark request / hold, active high |
| dout | output | DW | Output register |
| empty_n | output | 1 | High when a word can be read (low during setup) |
| ready_n | output | 1 | Fall-through mode: low when `dout` is valid; high in standard mode |
| rt_active | output | 1 | Bookmark held |
| mark_err | output | 1 | Sticky spacing violation |

## Verification
A replay request and a read strobe can land on the same edge. The bench drives `rt_n` and `rd_n` low together while a bookmark is held, then checks that the read returns the next word in order and that `empty_n` stays high, so no setup window opened. Writes can also fall inside the setup window. In fall-through mode the bench writes a word between the rewind and the reload, then drains the whole replay and checks that this word comes out last. In standard mode it fills up to the guard boundary and confirms that one extra write is dropped before the bookmark is released.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rtm_store.sv
module rtm_store #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtm_wr_ctrl.sv
module rtm_wr_ctrl #(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_n,
  input  logic [AW:0] rptr,
  input  logic        rt_active,
  input  logic [AW:0] mark_ptr,
  output logic [AW:0] wptr,
  output logic        we,
  output logic        full_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_q;
  logic [PW-1:0] used;
  logic [PW-1:0] span;
  logic          blocked;

  always_comb begin
    used    = wptr_q - rptr;
    span    = wptr_q - mark_ptr;
    // capacity limit, or one lap ahead of the bookmark
    blocked = (used == PW'(DEPTH)) || (rt_active && (span == PW'(DEPTH)));
  end

  always_ff @(posedge clk) begin
    if (rst) wptr_q <= '0;
    else if (!wr_n && !blocked) wptr_q <= wptr_q + 1'b1;
  end

  assign wptr   = wptr_q;
  assign we     = !wr_n && !blocked;
  assign full_n = !blocked;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wptr_q - rptr) <= PW'(DEPTH)); // R2
  AST_BLOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !wr_n) |=> $stable(wptr_q)); // R2
  AST_NO_MARK_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    rt_active |-> ((wptr_q - mark_ptr) <= PW'(DEPTH))); // R8
endmodule

// File: rtl/rtm_rd_ctrl.sv
module rtm_rd_ctrl import rtm_pkg::*; #(
  parameter int       AW        = 8,
  parameter int       MIN_GAP   = 128,
  parameter int       SETUP_LEN = 2,
  parameter rd_mode_e MODE      = RD_STD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_n,
  input  logic          rt_n,
  input  logic          mark,
  input  logic [AW:0]   wptr,
  output logic [AW:0]   rptr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   mark_ptr,
  output logic          rt_active,
  output logic          empty_n,
  output logic          ready_n,
  output logic          mark_err
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam int SW = $clog2(SETUP_LEN + 1);

  logic [PW-1:0] rptr_q, out_ptr_q, mark_ptr_q;
  logic [SW-1:0] setup_q;
  logic          out_valid_q, active_q, err_q;

  logic [PW-1:0] used;
  logic busy, has_data, flag_ok, gap_ok, mark_req, rt_go, re_raw, re_eff;

  always_comb begin
    used     = wptr - rptr_q;
    busy     = setup_q != '0;
    has_data = used != '0;
    if (MODE == RD_FWFT) begin
      re_raw  = (!out_valid_q || !rd_n) && has_data && !busy;
      flag_ok = out_valid_q && !busy;
    end else begin
      re_raw  = !rd_n && has_data && !busy;
      flag_ok = has_data && !busy;
    end
    gap_ok   = (used >= PW'(MIN_GAP)) && (used <= PW'(DEPTH - 2));
    mark_req = mark && !active_q && flag_ok;
    rt_go    = active_q && !rt_n && rd_n && !busy;
    re_eff   = re_raw && !rt_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q      <= '0;
      out_ptr_q   <= '1;
      mark_ptr_q  <= '0;
      setup_q     <= '0;
      out_valid_q <= 1'b0;
      active_q    <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (rt_go)       rptr_q <= mark_ptr_q;
      else if (re_eff) rptr_q <= rptr_q + 1'b1;

      if (re_eff) out_ptr_q <= rptr_q;

      if (rt_go)     setup_q <= SW'(SETUP_LEN);
      else if (busy) setup_q <= setup_q - 1'b1;

      if (rt_go)       out_valid_q <= 1'b0;
      else if (re_eff) out_valid_q <= 1'b1;
      else if (!rd_n)  out_valid_q <= 1'b0;

      if (!mark) active_q <= 1'b0;
      else if (mark_req && gap_ok) begin
        active_q   <= 1'b1;
        mark_ptr_q <= out_ptr_q;
      end

      if (mark_req && !gap_ok) err_q <= 1'b1;
    end
  end

  assign rptr      = rptr_q;
  assign re        = re_eff;
  assign raddr     = rptr_q[AW-1:0];
  assign mark_ptr  = mark_ptr_q;
  assign rt_active = active_q;
  assign empty_n   = has_data && !busy;
  assign ready_n   = (MODE == RD_FWFT) ? !out_valid_q : 1'b1;
  assign mark_err  = err_q;

  AST_PTR_FROZEN_IN_SETUP: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rptr_q)); // R5
  AST_SETUP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (active_q && !rt_n && rd_n && !busy) |=> (!empty_n && ready_n)); // R5
  AST_RT_SKIPPED_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (active_q && !rt_n && !rd_n && !busy) |=> (setup_q == '0)); // R4
  AST_MARK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !mark |=> !active_q); // R3
  AST_MARK_NEEDS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> ($past(used) >= PW'(MIN_GAP))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    mark_err |=> mark_err); // R9
endmodule

// File: rtl/fifo_rtm_ctrl.sv
module fifo_rtm_ctrl import rtm_pkg::*; #(
  parameter int       DW        = 16,
  parameter int       AW        = 8,
  parameter int       MIN_GAP   = 128,
  parameter int       SETUP_LEN = 2,
  parameter rd_mode_e MODE      = RD_STD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic          full_n,
  input  logic          rd_n,
  input  logic          rt_n,
  input  logic          mark,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          ready_n,
  output logic          rt_active,
  output logic          mark_err
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr, rptr, mark_ptr;
  logic          we, re;
  logic [AW-1:0] raddr;

  rtm_wr_ctrl #(.AW(AW)) u_wr (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rptr(rptr),
    .rt_active(rt_active), .mark_ptr(mark_ptr),
    .wptr(wptr), .we(we), .full_n(full_n)
  );

  rtm_rd_ctrl #(.AW(AW), .MIN_GAP(MIN_GAP), .SETUP_LEN(SETUP_LEN), .MODE(MODE)) u_rd (
    .clk(clk), .rst(rst), .rd_n(rd_n), .rt_n(rt_n), .mark(mark),
    .wptr(wptr), .rptr(rptr), .re(re), .raddr(raddr),
    .mark_ptr(mark_ptr), .rt_active(rt_active), .empty_n(empty_n),
    .ready_n(ready_n), .mark_err(mark_err)
  );

  rtm_store #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(we), .waddr(wptr[AW-1:0]), .wdata(din),
    .re(re), .raddr(raddr), .rdata(dout)
  );
endmodule

// File: tb/fifo_rtm_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_rtm_ctrl_tb_top;
  import rtm_pkg::*;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic s_wr_n = 1'b1, s_rd_n = 1'b1, s_rt_n = 1'b1, s_mark = 1'b0;
  logic [DW-1:0] s_din = '0;
  logic [DW-1:0] s_dout;
  logic s_full_n, s_empty_n, s_ready_n, s_rt_act, s_err;

  logic f_wr_n = 1'b1, f_rd_n = 1'b1, f_rt_n = 1'b1, f_mark = 1'b0;
  logic [DW-1:0] f_din = '0;
  logic [DW-1:0] f_dout;
  logic f_full_n, f_empty_n, f_ready_n, f_rt_act, f_err;

  fifo_rtm_ctrl #(.DW(DW), .MODE(RD_STD)) dut_i (
    .clk(clk), .rst(rst), .wr_n(s_wr_n), .din(s_din), .full_n(s_full_n),
    .rd_n(s_rd_n), .rt_n(s_rt_n), .mark(s_mark), .dout(s_dout),
    .empty_n(s_empty_n), .ready_n(s_ready_n), .rt_active(s_rt_act), .mark_err(s_err)
  );

  fifo_rtm_ctrl #(.DW(DW), .MODE(RD_FWFT)) dut_fw_i (
    .clk(clk), .rst(rst), .wr_n(f_wr_n), .din(f_din), .full_n(f_full_n),
    .rd_n(f_rd_n), .rt_n(f_rt_n), .mark(f_mark), .dout(f_dout),
    .empty_n(f_empty_n), .ready_n(f_ready_n), .rt_active(f_rt_act), .mark_err(f_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] s_log[$];
  logic [DW-1:0] f_log[$];
  logic [DW-1:0] exp_q[$];
  string exp_tag[$];
  int s_rd_idx = 0;
  int s_mark_idx = 0;
  logic fire_req = 1'b0;
  logic fire_q = 1'b0;

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chkw(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    s_wr_n = 1'b1; s_rd_n = 1'b1; s_rt_n = 1'b1; s_mark = 1'b0;
    f_wr_n = 1'b1; f_rd_n = 1'b1; f_rt_n = 1'b1; f_mark = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    s_log.delete(); f_log.delete(); exp_q.delete(); exp_tag.delete();
    s_rd_idx = 0;
  endtask

  task automatic s_write(input logic [DW-1:0] v, input bit keep);
    s_wr_n = 1'b0; s_din = v;
    if (keep) s_log.push_back(v);
    tick();
    s_wr_n = 1'b1;
  endtask

  task automatic f_write(input logic [DW-1:0] v);
    f_wr_n = 1'b0; f_din = v;
    f_log.push_back(v);
    tick();
    f_wr_n = 1'b1;
  endtask

  // driver side of the scoreboard: queue the expected word, strobe the read
  task automatic s_read(input string tag);
    exp_q.push_back(s_log[s_rd_idx]);
    exp_tag.push_back(tag);
    s_rd_idx++;
    s_rd_n = 1'b0; fire_req = 1'b1;
    tick();
    s_rd_n = 1'b1; fire_req = 1'b0;
  endtask

  task automatic s_retransmit();
    s_rt_n = 1'b0;
    tick();
    s_rt_n = 1'b1;
    chk1("R5 empty_n low in setup (1)", s_empty_n, 1'b0);
    s_rd_n = 1'b0;              // read attempt inside the window must be blocked
    tick();
    s_rd_n = 1'b1;
    chk1("R5 empty_n low in setup (2)", s_empty_n, 1'b0);
    tick();
    chk1("R5 empty_n back after setup", s_empty_n, 1'b1);
    s_rd_idx = s_mark_idx;
  endtask

  // monitor side of the scoreboard
  always @(posedge clk) fire_q <= fire_req;

  always @(negedge clk) begin : monitor
    logic [DW-1:0] e;
    string t;
    if (fire_q) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard underflow actual=%0h expected=none", s_dout);
      end else begin
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        if (s_dout !== e) begin
          n_fail++;
          $display("FAIL %s read data actual=%0h expected=%0h", t, s_dout, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run hung actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int bad;
    do_reset();
    // R10 reset state
    chk1("R10 empty_n", s_empty_n, 1'b0);
    chk1("R10 full_n", s_full_n, 1'b1);
    chk1("R10 ready_n", s_ready_n, 1'b1);
    chk1("R10 rt_active", s_rt_act, 1'b0);
    chk1("R10 mark_err", s_err, 1'b0);
    chk1("R10 fwft ready_n", f_ready_n, 1'b1);

    // R11 bookmark while empty is ignored
    s_mark = 1'b1; tick();
    chk1("R11 rt_active stays low", s_rt_act, 1'b0);
    chk1("R11 no error", s_err, 1'b0);
    s_mark = 1'b0; tick();

    for (int i = 0; i < 200; i++) s_write(DW'(i) + 16'h1000, 1'b1);
    chk1("R1 empty_n after writes", s_empty_n, 1'b1);
    for (int i = 0; i < 10; i++) s_read("R1");

    // R4 replay without bookmark has no effect
    s_rt_n = 1'b0; tick(); s_rt_n = 1'b1;
    chk1("R4 no setup without bookmark", s_empty_n, 1'b1);

    s_mark = 1'b1; s_mark_idx = s_rd_idx - 1; tick();
    chk1("R3 rt_active set", s_rt_act, 1'b1);
    chk1("R9 no error on good spacing", s_err, 1'b0);
    for (int i = 0; i < 5; i++) s_read("R1");

    // R4 collision: replay request with read strobe
    s_rt_n = 1'b0;
    s_read("R4 read wins over replay");
    s_rt_n = 1'b1;
    chk1("R4 no setup on collision", s_empty_n, 1'b1);
    s_read("R4 order kept");

    s_retransmit();
    for (int i = 0; i < 3; i++) s_read("R6 replay from bookmark");

    // R8 guard: wptr 200, bookmark slot 9 -> limit at 265
    for (int i = 0; i < 65; i++) s_write(DW'(i) + 16'h2000, 1'b1);
    chk1("R8 full_n at guard", s_full_n, 1'b0);
    s_write(16'hDEAD, 1'b0);
    chk1("R8 still blocked", s_full_n, 1'b0);
    s_mark = 1'b0; tick();
    chk1("R3 rt_active cleared", s_rt_act, 1'b0);
    chk1("R8 guard lifted", s_full_n, 1'b1);
    while (s_rd_idx < s_log.size()) s_read("R8 drain");
    chk1("R8 blocked word not stored", s_empty_n, 1'b0);

    // R3 a later bookmark replaces the earlier one
    do_reset();
    for (int i = 0; i < 200; i++) s_write(DW'(i) + 16'h4000, 1'b1);
    for (int i = 0; i < 5; i++) s_read("R1");
    s_mark = 1'b1; tick(); s_mark = 1'b0; tick();
    chk1("R3 release", s_rt_act, 1'b0);
    for (int i = 0; i < 3; i++) s_read("R1");
    s_mark = 1'b1; s_mark_idx = s_rd_idx - 1; tick();
    chk1("R3 second bookmark", s_rt_act, 1'b1);
    s_retransmit();
    s_read("R3 new bookmark word");
    s_read("R6 next after bookmark");
    s_mark = 1'b0; tick();

    // R2 capacity
    do_reset();
    for (int i = 0; i < 255; i++) s_write(DW'(i) + 16'h5000, 1'b1);
    chk1("R2 one slot left", s_full_n, 1'b1);
    s_write(16'h50FF, 1'b1);
    chk1("R2 full", s_full_n, 1'b0);
    s_write(16'hBEEF, 1'b0);
    chk1("R2 still full", s_full_n, 1'b0);
    for (int i = 0; i < 256; i++) s_read("R2 drain");
    chk1("R2 extra word dropped", s_empty_n, 1'b0);

    // R9 spacing below MIN_GAP
    do_reset();
    for (int i = 0; i < 20; i++) s_write(DW'(i) + 16'h6000, 1'b1);
    s_read("R9");
    s_mark = 1'b1; tick();
    chk1("R9 short spacing rejected", s_rt_act, 1'b0);
    chk1("R9 error set", s_err, 1'b1);
    s_mark = 1'b0; tick();
    chk1("R9 error sticky", s_err, 1'b1);
    s_read("R9 data unaffected");

    // R9 spacing above DEPTH-2
    do_reset();
    chk1("R9 reset clears error", s_err, 1'b0);
    for (int i = 0; i < 256; i++) s_write(DW'(i) + 16'h7000, 1'b1);
    s_read("R9");
    s_mark = 1'b1; tick();
    chk1("R9 near-full rejected", s_rt_act, 1'b0);
    chk1("R9 error on near-full", s_err, 1'b1);
    s_mark = 1'b0; tick();

    // fall-through mode
    do_reset();
    for (int i = 0; i < 150; i++) f_write(DW'(i) + 16'h3000);
    tick();
    chk1("R7 head valid", f_ready_n, 1'b0);
    chkw("R7 head falls through", f_dout, f_log[0]);
    for (int i = 0; i < 5; i++) begin f_rd_n = 1'b0; tick(); f_rd_n = 1'b1; end
    chkw("R7 consumed five", f_dout, f_log[5]);
    f_mark = 1'b1; tick();
    chk1("R7 bookmark on ready", f_rt_act, 1'b1);
    for (int i = 0; i < 3; i++) begin f_rd_n = 1'b0; tick(); f_rd_n = 1'b1; end
    chkw("R7 advanced", f_dout, f_log[8]);
    f_rt_n = 1'b0; tick(); f_rt_n = 1'b1;
    chk1("R5 ready_n high (1)", f_ready_n, 1'b1);
    f_wr_n = 1'b0; f_din = 16'h3ABC; f_log.push_back(16'h3ABC);
    tick();
    f_wr_n = 1'b1;
    chk1("R5 ready_n high (2)", f_ready_n, 1'b1);
    tick();
    chk1("R5 ready_n high until reload", f_ready_n, 1'b1);
    tick();
    chk1("R7 ready after setup", f_ready_n, 1'b0);
    chkw("R7 bookmark word reloaded", f_dout, f_log[5]);
    tick();
    chkw("R7 held without rd_n", f_dout, f_log[5]);
    f_rd_n = 1'b0; tick(); f_rd_n = 1'b1;
    chkw("R7 next word needs rd_n", f_dout, f_log[6]);
    f_mark = 1'b0; tick();
    chk1("R3 fwft release", f_rt_act, 1'b0);
    bad = 0;
    for (int k = 7; k < 151; k++) begin
      f_rd_n = 1'b0; tick(); f_rd_n = 1'b1;
      if (f_dout !== f_log[k] && bad == 0) bad = k;
    end
    chkw("R7 replay drain order", DW'(bad), 16'h0);
    f_rd_n = 1'b0; tick(); f_rd_n = 1'b1;
    chk1("R7 drained", f_ready_n, 1'b1);

    tick();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule